// File: doc/BRIEF.md
# Bus-Activity Kicked Watchdog Timer

This block is a watchdog timer that needs no dedicated kick pin. It watches the two lines of a shared two-wire serial bus (clock and data) and treats one specific pattern on them as a restart. The pattern is a start condition, then a falling clock, then a stop condition. The data line is sampled every cycle whether or not any transfer is addressed to this block. Both lines are taken through multi-flop synchronizers before any edge is examined.

A counter runs on the free-running system clock. A 2-bit select picks the counter limit from three preset counts, or turns the watchdog off. When the limit is reached without a restart, the active-low watchdog output asserts. A separate drive-low enable is provided for an open-drain pad and is high exactly while the output is active. Once the output is active it stays active until the next complete restart pattern, which clears it and starts the count again from zero.

Top module: `bus_kick_wdt`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, `wdt_n` is 1 and `wdt_pull` is 0. Counting starts from zero.
- R2: Select codes 2'b00, 2'b01 and 2'b10 choose the limits TO_0, TO_1 and TO_2. `wdt_n` falls exactly limit cycles after the last reload (reset, restart or re-enable) and is high on the cycle before.
- R3: A restart has three steps in this order. First a start: data falls while clock is high. Second, clock falls. Third, a stop: data rises while clock is high. With SYNC_STAGES=2, the restart reloads the counter and releases `wdt_n` 4 clock edges after the stop's data edge is applied at the input.
- R4: `wdt_n` is active low, and `wdt_pull` is 1 exactly when `wdt_n` is 0.
- R5: Once `wdt_n` is 0 it stays 0, however long the bus is idle, until a valid restart or the off code.
- R6: A start followed by a clock fall, with no stop afterwards, does not restart the counter.
- R7: A stop that is not preceded by a start does not restart the counter.
- R8: A start followed directly by a stop, with no clock fall between them, does not restart the counter.
- R9: Select code 2'b11 turns the watchdog off. The next cycle `wdt_n` is 1, even if it was active, and it stays 1. Leaving the code restarts counting from zero.
- R10: A start, a clock fall, and then a second start re-arm the detector. A stop that follows the second start with no new clock fall does not restart the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial bus clock line, asynchronous |
| sda_in | input | 1 | Serial bus data line, asynchronous |
| to_sel | input | 2 | Timeout select: 00/01/10 = TO_0/TO_1/TO_2, 11 = off |
| wdt_n | output | 1 | Watchdog output, active low |
| wdt_pull | output | 1 | Open-drain drive-low enable, 1 while `wdt_n` is low |

## Verification
The bench builds the block with limits of 20, 40 and 70 cycles and two synchronizer stages, in place of the large defaults. At these sizes every limit can be checked at its exact expiry cycle, and each partial bus pattern fits inside a single timeout window. The directed cases place each malformed pattern between a reload and its expiry, then confirm that expiry still lands on the original cycle. Random gaps around each limit exercise both sides of the boundary under all three enabled codes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    KD_IDLE    = 2'd0,
    KD_ARMED   = 2'd1,
    KD_CLOCKED = 2'd2
  } kd_state_e;

  localparam logic [1:0] SEL_OFF = 2'b11;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/kick_detect.sv
module kick_detect
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic kick
);
  logic      scl_d, sda_d;
  kd_state_e st, st_nx;
  logic      start_c, stop_c, scl_fall_c, kick_nx;

  assign start_c    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c     = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_fall_c = scl_d & ~scl_s;

  always_comb begin
    st_nx   = st;
    kick_nx = 1'b0;
    unique case (st)
      KD_IDLE:    if (start_c) st_nx = KD_ARMED;
      KD_ARMED: begin
        if (stop_c)          st_nx = KD_IDLE;
        else if (scl_fall_c) st_nx = KD_CLOCKED;
      end
      KD_CLOCKED: begin
        if (stop_c) begin
          st_nx   = KD_IDLE;
          kick_nx = 1'b1;
        end else if (start_c) begin
          st_nx = KD_ARMED;
        end
      end
      default:    st_nx = KD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      st    <= KD_IDLE;
      kick  <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      st    <= st_nx;
      kick  <= kick_nx;
    end
  end
endmodule

// File: rtl/timeout_counter.sv
module timeout_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TO_0  = 20,
  parameter int unsigned TO_1  = 40,
  parameter int unsigned TO_2  = 70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       kick,
  output logic       expired
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             off;

  assign off = (sel == SEL_OFF);

  always_comb begin
    unique case (sel)
      2'b00:   limit = CNT_W'(TO_0);
      2'b01:   limit = CNT_W'(TO_1);
      2'b10:   limit = CNT_W'(TO_2);
      default: limit = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || off || kick) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt >= limit - 1'b1) expired <= 1'b1;
      else                     cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_kick_wdt.sv
module bus_kick_wdt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TO_0        = 25_000_000,
  parameter int unsigned TO_1        = 50_000_000,
  parameter int unsigned TO_2        = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] to_sel,
  output logic       wdt_n,
  output logic       wdt_pull
);
  localparam int unsigned MAX_A = (TO_0 > TO_1) ? TO_0 : TO_1;
  localparam int unsigned MAX_TO = (MAX_A > TO_2) ? MAX_A : TO_2;
  localparam int unsigned CNT_W = $clog2(MAX_TO) + 1;

  logic [1:0] lines_s;
  logic       scl_s, sda_s, kick, expired;

  bus_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  kick_detect u_kick (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .kick(kick)
  );

  timeout_counter #(.CNT_W(CNT_W), .TO_0(TO_0), .TO_1(TO_1), .TO_2(TO_2)) u_cnt (
    .clk(clk), .rst(rst), .sel(to_sel), .kick(kick), .expired(expired)
  );

  assign wdt_n    = ~expired;
  assign wdt_pull = expired;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] to_sel,
  input logic       scl_s,
  input logic       sda_s,
  input logic       kick,
  input logic       wdt_n
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> wdt_n);

  // R3
  kick_src_chk: assert property (@(posedge clk) disable iff (rst)
    kick |-> ($past(scl_s) && $past(sda_s) && !$past(sda_s, 2)));

  // R3
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> wdt_n);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!wdt_n && !kick && to_sel != 2'b11) |=> !wdt_n);

  // R9
  off_chk: assert property (@(posedge clk) disable iff (rst)
    (to_sel == 2'b11) |=> wdt_n);

  // R2
  fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_n) |-> ($past(to_sel) != 2'b11 && !$past(kick)));
endmodule

bind bus_kick_wdt wdt_checker u_chk (
  .clk(clk), .rst(rst), .to_sel(to_sel), .scl_s(scl_s),
  .sda_s(sda_s), .kick(kick), .wdt_n(wdt_n)
);

// File: tb/tb_bus_kick_wdt.sv
`timescale 1ns/1ps
module tb_bus_kick_wdt;
  localparam int T0 = 20, T1 = 40, T2 = 70;

  logic       clk = 1'b0, rst = 1'b1, scl = 1'b1, sda = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       wdt_n, wdt_pull;
  int         cyc = 0, n_chk = 0, n_fail = 0, ref_c = 0;
  bit         done = 0;

  bus_kick_wdt #(.SYNC_STAGES(2), .TO_0(T0), .TO_1(T1), .TO_2(T2)) dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .to_sel(sel),
    .wdt_n(wdt_n), .wdt_pull(wdt_pull)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lim(input logic [1:0] s);
    return (s == 2'b00) ? T0 : (s == 2'b01) ? T1 : T2;
  endfunction

  function automatic logic exp_n(input int r, input int t);
    return (cyc - r >= t) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, wdt_n, exp);
    chk({req, "/R4"}, wdt_pull, ~exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic lines(input logic c, input logic d);
    scl = c; sda = d;
    step(3);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    step(3);
    rst = 1'b0;
    ref_c = cyc;
  endtask

  task automatic do_kick();
    lines(1, 1);
    lines(1, 0);
    lines(0, 0);
    lines(1, 0);
    sda = 1'b1;
    ref_c = cyc + 4;
    step(3);
  endtask

  task automatic chk_expiry(input string req, input int t);
    wait_until(ref_c + t - 1);
    chk_out(req, 1'b1);
    step(1);
    chk_out(req, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    step(1);
    do_reset();
    chk_out("R1", 1'b1);
    step(1);
    chk_out("R1", 1'b1);
    // R2 exact limit for code 00
    chk_expiry("R2", T0);
    // R5 stays active while bus idle
    step(30);
    chk_out("R5", 1'b0);
    // R3 restart: still low one edge before reload, then released
    do_kick();
    wait_until(ref_c - 1);
    chk_out("R3", 1'b0);
    step(1);
    chk_out("R3", 1'b1);
    chk_expiry("R3", T0);
    // R2 codes 01 and 10 from reset
    sel = 2'b01; do_reset(); chk_expiry("R2", T1);
    sel = 2'b10; do_reset(); chk_expiry("R2", T2);
    sel = 2'b01;
    // R6 start and clock fall without stop
    do_kick(); step(5);
    lines(1, 0); lines(0, 0); lines(0, 1); lines(1, 1);
    chk_expiry("R6", T1);
    // R7 stop with no start
    do_kick(); step(5);
    lines(0, 1); lines(0, 0); lines(1, 0); lines(1, 1);
    chk_expiry("R7", T1);
    // R8 start then stop with no clock fall
    do_kick(); step(5);
    lines(1, 0); lines(1, 1);
    chk_expiry("R8", T1);
    // R10 second start re-arms, stop without new clock fall
    do_kick(); step(5);
    lines(1, 0); lines(0, 0); lines(0, 1); lines(1, 1); lines(1, 0); lines(1, 1);
    chk_expiry("R10", T1);
    // R9 off code clears an active output and holds it
    step(3);
    chk_out("R9", 1'b0);
    sel = 2'b11;
    step(1);
    chk_out("R9", 1'b1);
    step(150);
    chk_out("R9", 1'b1);
    sel = 2'b10;
    ref_c = cyc;
    chk_expiry("R9", T2);
    // random gaps around the limits (R2, R3)
    for (int i = 0; i < 40; i++) begin
      int g;
      sel = 2'($urandom_range(2, 0));
      do_kick();
      g = int'($urandom_range(2 * lim(sel) + 8, 0));
      wait_until(ref_c + g);
      chk_out("R2", exp_n(ref_c, lim(sel)));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule